// File: doc/BRIEF.md
# Dual-Port Flag Mailbox

This block is a small shared memory with two synchronous byte ports on one clock. A host port on the fast side and a controller port on the slower side both read and write it. It carries message frames in both directions between a host bus and a field-bus controller. Flow control comes only from flag bytes stored in the memory itself. There are no hardware queue pointers and no semaphores.

The memory holds two 16-byte regions, one for each direction. Inside a region, offset 0 is the flag, offset 1 is the length and offsets 2..15 are data. The controller-to-host region starts at address 0x00, so its flag is the first byte of the memory. The host-to-controller region starts at address 0x20.

A producer first writes the data bytes and the length, and only then writes the ready code 0xA5 into the flag. The consumer polls the flag, reads the frame, and writes 0x00 back to the flag to release the region. Two status outputs show when each flag holds the ready code, so a user can watch the flags without polling them.

Top module: `mbx_dualport`

## Requirements
- R1: After reset every byte reads 0x00, both read-data outputs are 0x00, and `ctl_busy`, `tx_pending` and `rx_pending` are low.
- R2: A read on either port puts the addressed byte on that port's read-data output at the next rising edge (one-cycle latency).
- R3: A byte written by one port can be read by the other port in the following cycle.
- R4: If one port reads an address in the same cycle that the other port writes it, the read returns the value held before the write.
- R5: If both ports write the same address in the same cycle, the host value is stored, the controller value is dropped, and `ctl_busy` is high for exactly the next cycle.
- R6: Writes from both ports to different addresses in the same cycle both take effect, and `ctl_busy` stays low.
- R7: `tx_pending` is high exactly when byte 0x20 (the host-to-controller flag) equals 0xA5. It reflects a write from the cycle after that write.
- R8: `rx_pending` is high exactly when byte 0x00 (the controller-to-host flag) equals 0xA5. Any other value, for example 0x5A, leaves it low.
- R9: Writing the idle value 0x00 to a flag drops the matching pending output in the next cycle, which hands the region back to the producer.
- R10: While a port's read strobe is low, its read-data output holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 6 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data, one cycle after `host_rd` |
| ctl_addr | input | 6 | Controller byte address |
| ctl_wdata | input | 8 | Controller write data |
| ctl_wr | input | 1 | Controller write strobe |
| ctl_rd | input | 1 | Controller read strobe |
| ctl_rdata | output | 8 | Controller read data, one cycle after `ctl_rd` |
| ctl_busy | output | 1 | One-cycle pulse: the controller's write lost a same-address collision |
| tx_pending | output | 1 | Host-to-controller flag holds the ready code |
| rx_pending | output | 1 | Controller-to-host flag holds the ready code |

## Verification
The assertions assume the strobes and addresses are clean values on each rising edge. They also assume a controller write that loses a collision is seen as lost through `ctl_busy`, and is not expected in memory. The bench drives every input at the falling edge and keeps the strobes at zero during reset. It builds collisions on purpose, including one on a flag byte, so the priority rule and the pending outputs are checked together. The flag-handshake sequences follow the data-first, flag-last order for both directions, so a pending output never rises before its frame bytes are in memory.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // Registered state of the write arbiter
    typedef struct packed {
        logic busy;
    } arb_state_t;

    // Flag values used by the handshake
    localparam logic [7:0] MBX_READY = 8'hA5;
    localparam logic [7:0] MBX_IDLE  = 8'h00;
endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              c_wr,
    input  logic [ADDR_W-1:0] c_addr,
    output logic              h_we,
    output logic              c_we,
    output logic              busy
);
    import mbx_pkg::*;

    arb_state_t st_d, st_q;
    logic       clash;

    always_comb begin
        clash      = h_wr && c_wr && (h_addr == c_addr);
        h_we       = h_wr;
        c_we       = c_wr && !clash;
        st_d       = st_q;
        st_d.busy  = clash;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    // R5
    busy_after_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && c_wr && h_addr == c_addr) |=> busy);
    // R6
    no_busy_without_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_wr && c_wr && h_addr == c_addr) |=> !busy);
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 8,
    parameter int FLAG_A  = 32,
    parameter int FLAG_B  = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   h_we,
    input  logic                   h_rd,
    input  logic [ADDR_W-1:0]      h_addr,
    input  logic [DATA_W-1:0]      h_wdata,
    output logic [DATA_W-1:0]      h_rdata,
    input  logic                   c_we,
    input  logic                   c_rd,
    input  logic [ADDR_W-1:0]      c_addr,
    input  logic [DATA_W-1:0]      c_wdata,
    output logic [DATA_W-1:0]      c_rdata,
    output logic [1:0][DATA_W-1:0] flag_bytes
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int FLAG_ADDR [2] = '{FLAG_A, FLAG_B};

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rd_h;
        logic [DATA_W-1:0]            rd_c;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // reads sample the old contents: read-before-write
        if (h_rd) st_d.rd_h = st_q.mem[h_addr];
        if (c_rd) st_d.rd_c = st_q.mem[c_addr];
        if (c_we) st_d.mem[c_addr] = c_wdata;
        // host written last so it wins any overlap
        if (h_we) st_d.mem[h_addr] = h_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_rdata = st_q.rd_h;
    assign c_rdata = st_q.rd_c;

    for (genvar g = 0; g < 2; g++) begin : g_flag
        assign flag_bytes[g] = st_q.mem[FLAG_ADDR[g]];
    end

    // R2
    host_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd |=> h_rdata == $past(st_q.mem[h_addr]));
    // R4
    ctl_read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && h_we && c_addr == h_addr) |=> c_rdata == $past(st_q.mem[c_addr]));
    // R5
    no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && c_we) |-> h_addr != c_addr);
    // R10
    host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !h_rd |=> $stable(h_rdata));
    // R10
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rd |=> $stable(c_rdata));
endmodule

// File: rtl/mbx_flag_mon.sv
module mbx_flag_mon #(
    parameter int               DATA_W = 8,
    parameter logic [DATA_W-1:0] READY  = 8'hA5
) (
    input  logic [DATA_W-1:0] flag,
    output logic              pending
);
    always_comb pending = (flag == READY);
endmodule

// File: rtl/mbx_dualport.sv
module mbx_dualport #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 8,
    parameter int TX_BASE = 32,
    parameter int RX_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              ctl_busy,
    output logic              tx_pending,
    output logic              rx_pending
);
    import mbx_pkg::*;

    localparam int TX_FLAG = TX_BASE;
    localparam int RX_FLAG = RX_BASE;

    logic                   h_we, c_we;
    logic [1:0][DATA_W-1:0] flags;
    logic [1:0]             pend;

    mbx_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .h_wr(host_wr), .h_addr(host_addr),
        .c_wr(ctl_wr),  .c_addr(ctl_addr),
        .h_we(h_we), .c_we(c_we), .busy(ctl_busy)
    );

    mbx_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_A(TX_FLAG), .FLAG_B(RX_FLAG)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we), .h_rd(host_rd), .h_addr(host_addr), .h_wdata(host_wdata), .h_rdata(host_rdata),
        .c_we(c_we), .c_rd(ctl_rd),  .c_addr(ctl_addr),  .c_wdata(ctl_wdata),  .c_rdata(ctl_rdata),
        .flag_bytes(flags)
    );

    for (genvar g = 0; g < 2; g++) begin : g_mon
        mbx_flag_mon #(.DATA_W(DATA_W), .READY(DATA_W'(MBX_READY))) u_mon (
            .flag(flags[g]), .pending(pend[g])
        );
    end

    assign tx_pending = pend[0];
    assign rx_pending = pend[1];

    // R7
    tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_W'(TX_FLAG) && host_wdata == DATA_W'(MBX_READY)) |=> tx_pending);
    // R8
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_addr == ADDR_W'(RX_FLAG) && ctl_wdata == DATA_W'(MBX_READY)
         && !(host_wr && host_addr == ADDR_W'(RX_FLAG))) |=> rx_pending);
    // R9
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_W'(TX_FLAG) && host_wdata == DATA_W'(MBX_IDLE)) |=> !tx_pending);
endmodule

// File: tb/tb_mbx_dualport.sv
module tb_mbx_dualport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] host_addr = '0, ctl_addr = '0;
    logic [7:0] host_wdata = '0, ctl_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0, ctl_wr = 1'b0, ctl_rd = 1'b0;
    logic [7:0] host_rdata, ctl_rdata;
    logic       ctl_busy, tx_pending, rx_pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mbx_dualport dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
        .host_rdata(host_rdata),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
        .ctl_rdata(ctl_rdata), .ctl_busy(ctl_busy),
        .tx_pending(tx_pending), .rx_pending(rx_pending)
    );

    typedef struct packed {
        logic       hw; logic hr; logic [5:0] ha; logic [7:0] hd;
        logic       cw; logic cr; logic [5:0] ca; logic [7:0] cd;
        logic       chk_h; logic [7:0] exp_h;
        logic       chk_c; logic [7:0] exp_c;
        logic       exp_busy; logic exp_tx; logic exp_rx;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,6'h21,8'h03, 1'b0,1'b0,6'h00,8'h00, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0,1'b0}, // length byte
        '{1'b1,1'b0,6'h22,8'h11, 1'b0,1'b1,6'h21,8'h00, 1'b0,8'h00, 1'b1,8'h03, 1'b0,1'b0,1'b0}, // R3
        '{1'b1,1'b0,6'h20,8'hA5, 1'b0,1'b1,6'h22,8'h00, 1'b0,8'h00, 1'b1,8'h11, 1'b0,1'b1,1'b0}, // R7
        '{1'b0,1'b0,6'h00,8'h00, 1'b0,1'b1,6'h20,8'h00, 1'b0,8'h00, 1'b1,8'hA5, 1'b0,1'b1,1'b0}, // R2
        '{1'b0,1'b1,6'h20,8'h00, 1'b1,1'b0,6'h20,8'h00, 1'b1,8'hA5, 1'b0,8'h00, 1'b0,1'b0,1'b0}, // R4 R9
        '{1'b0,1'b1,6'h20,8'h00, 1'b0,1'b0,6'h00,8'h00, 1'b1,8'h00, 1'b0,8'h00, 1'b0,1'b0,1'b0}, // R3
        '{1'b0,1'b0,6'h00,8'h00, 1'b1,1'b0,6'h02,8'h77, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0,1'b0},
        '{1'b0,1'b1,6'h02,8'h00, 1'b1,1'b0,6'h00,8'h5A, 1'b1,8'h77, 1'b0,8'h00, 1'b0,1'b0,1'b0}, // R8 not ready
        '{1'b0,1'b0,6'h00,8'h00, 1'b1,1'b0,6'h00,8'hA5, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0,1'b1}, // R8
        '{1'b0,1'b1,6'h00,8'h00, 1'b0,1'b0,6'h00,8'h00, 1'b1,8'hA5, 1'b0,8'h00, 1'b0,1'b0,1'b1}, // R2
        '{1'b1,1'b0,6'h00,8'h00, 1'b0,1'b1,6'h00,8'h00, 1'b0,8'h00, 1'b1,8'hA5, 1'b0,1'b0,1'b0}, // R4 R9
        '{1'b1,1'b0,6'h30,8'hC3, 1'b1,1'b0,6'h30,8'h3C, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0,1'b0}, // R5
        '{1'b0,1'b0,6'h00,8'h00, 1'b0,1'b1,6'h30,8'h00, 1'b0,8'h00, 1'b1,8'hC3, 1'b0,1'b0,1'b0}, // R5
        '{1'b1,1'b0,6'h31,8'h44, 1'b1,1'b0,6'h32,8'h55, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0,1'b0}, // R6
        '{1'b0,1'b1,6'h32,8'h00, 1'b0,1'b1,6'h31,8'h00, 1'b1,8'h55, 1'b1,8'h44, 1'b0,1'b0,1'b0}, // R6
        '{1'b0,1'b0,6'h05,8'h00, 1'b0,1'b0,6'h06,8'h00, 1'b1,8'h55, 1'b1,8'h44, 1'b0,1'b0,1'b0}, // R10
        '{1'b1,1'b0,6'h20,8'h00, 1'b1,1'b0,6'h20,8'hA5, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0,1'b0}  // R5 on flag
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        host_wr = 1'b0; host_rd = 1'b0; ctl_wr = 1'b0; ctl_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 host_rdata", host_rdata, 8'h00);
        chk("R1 ctl_rdata", ctl_rdata, 8'h00);
        chk("R1 busy", {7'd0, ctl_busy}, 8'h00);
        chk("R1 tx_pending", {7'd0, tx_pending}, 8'h00);
        chk("R1 rx_pending", {7'd0, rx_pending}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            host_wr = VECS[i].hw; host_rd = VECS[i].hr; host_addr = VECS[i].ha; host_wdata = VECS[i].hd;
            ctl_wr  = VECS[i].cw; ctl_rd  = VECS[i].cr; ctl_addr  = VECS[i].ca; ctl_wdata  = VECS[i].cd;
            @(negedge clk);
            idle_inputs();
            if (VECS[i].chk_h) chk($sformatf("R2/R3/R4 vec%0d host_rdata", i), host_rdata, VECS[i].exp_h);
            if (VECS[i].chk_c) chk($sformatf("R2/R3/R4 vec%0d ctl_rdata", i), ctl_rdata, VECS[i].exp_c);
            chk($sformatf("R5/R6 vec%0d busy", i), {7'd0, ctl_busy}, {7'd0, VECS[i].exp_busy});
            chk($sformatf("R7/R9 vec%0d tx_pending", i), {7'd0, tx_pending}, {7'd0, VECS[i].exp_tx});
            chk($sformatf("R8/R9 vec%0d rx_pending", i), {7'd0, rx_pending}, {7'd0, VECS[i].exp_rx});
        end

        // R5: busy lasts exactly one cycle after the clash (no new stimulus)
        @(negedge clk);
        chk("R5 busy single cycle", {7'd0, ctl_busy}, 8'h00);
        // R5: flag still idle, host value 0x00 kept
        host_rd = 1'b1; host_addr = 6'h20;
        @(negedge clk); idle_inputs();
        chk("R5 flag kept host value", host_rdata, 8'h00);

        // R1: mid-run reset clears memory and flags
        host_wr = 1'b1; host_addr = 6'h20; host_wdata = 8'hA5;
        @(negedge clk); idle_inputs();
        chk("R7 tx set before reset", {7'd0, tx_pending}, 8'h01);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 tx cleared by reset", {7'd0, tx_pending}, 8'h00);
        ctl_rd = 1'b1; ctl_addr = 6'h30;
        @(negedge clk); idle_inputs();
        chk("R1 memory cleared", ctl_rdata, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule